// File: doc/BRIEF.md
# Smart-Card Answer-to-Reset Sequencer

This block runs the answer-to-reset phase of a contact smart card for a host. The host writes a single 8-bit control word that switches the card on or off, sets the reset contact by hand, starts an automatic reset sequence and sets four spare output lines. Once the automatic mode is armed, the block does the reset timing on its own. It holds the card reset contact low for a set number of card clock pulses and then raises it. It then waits for the card to begin its answer, which shows as a falling edge on the I/O line.

The automatic mode ends in one of two ways. If a start bit comes in time, the block disarms itself and keeps reset high, because the card is now answering. If the card stays silent for twice the window, the block declares the card mute, disarms itself and drops reset. Each outcome gives a one-cycle pulse and sets a sticky flag, and any write to the control word clears both flags. Arming the automatic mode again while the card is powered starts a warm reset. Card clock pulses arrive as a one-cycle `card_clk_tick` strobe in the system clock domain.

Top module: `atr_seq`

## Requirements
- R1: After reset every control bit is 0: `vcc_on`=0, `card_rst`=0, `auto_on`=0, `aux_n`=4'hF, and both pulses and both flags are 0.
- R2: A write sets `vcc_on` to `wr_data[0]` from the next cycle on. A 1 means activate and a 0 means deactivate.
- R3: While `auto_on` is 0 and the card is active, `card_rst` equals the manual reset bit `wr_data[1]` from the last write.
- R4: Writing `wr_data[2]`=1 together with `wr_data[0]`=1 sets `auto_on` and restarts the pulse count from zero. `card_rst` then stays low for WIN_CLKS ticks and is high from the tick that brings the count to WIN_CLKS. The manual reset bit has no effect during this time.
- R5: A falling edge on `card_io` while `auto_on`=1 and reset is already high clears `auto_on`, gives a one-cycle `atr_pulse`, sets `atr_flag` and leaves `card_rst` high.
- R6: A falling edge on `card_io` while reset is still low during the automatic sequence is ignored: `auto_on` stays 1 and no pulse is given.
- R7: If the tick that brings the count to 2×WIN_CLKS arrives with no valid start bit, `auto_on` clears, `card_rst` drops, `mute_pulse` lasts one cycle and `mute_flag` is set.
- R8: Writing the automatic enable again while the card is active, including during or after a sequence, drops `card_rst` low on the next cycle and reruns the sequence. `vcc_on` stays 1.
- R9: A write with `wr_data[0]`=0 drops `card_rst` low and clears `auto_on`, which aborts any sequence in progress.
- R10: `aux_n[i]` is the inverse of `wr_data[4+i]` from the last write, whatever state the card is in.
- R11: Every write clears `atr_flag` and `mute_flag`. A write takes priority over a start bit or tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word: bit0 activate, bit1 manual reset, bit2 auto enable, bits7:4 aux |
| card_clk_tick | input | 1 | One-cycle strobe per card clock pulse |
| card_io | input | 1 | Card I/O line, idle high |
| vcc_on | output | 1 | Card activation state |
| card_rst | output | 1 | Card reset contact level |
| auto_on | output | 1 | Automatic sequence armed |
| aux_n | output | 4 | Inverted auxiliary outputs |
| atr_pulse | output | 1 | One-cycle valid start bit indication |
| mute_pulse | output | 1 | One-cycle mute indication |
| atr_flag | output | 1 | Sticky start bit seen |
| mute_flag | output | 1 | Sticky card mute |

## Verification
The bench puts a start bit inside the reset-low window. A design that accepted it would disarm early and report an answer that is not there. It lets a silent card run to the exact mute tick, where an off-by-one counter would declare mute one tick early or late. It rewrites the enable in the middle of a sequence and after a finished one, where a design that does not restart the count would keep reset high and skip the warm reset. It also clears the activation bit during a sequence, which shows whether reset stays up or the enable survives the abort.

// File: rtl/atr_seq.sv
module atr_seq #(
  parameter int WIN_CLKS = 40100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       card_clk_tick,
  input  logic       card_io,
  output logic       vcc_on,
  output logic       card_rst,
  output logic       auto_on,
  output logic [3:0] aux_n,
  output logic       atr_pulse,
  output logic       mute_pulse,
  output logic       atr_flag,
  output logic       mute_flag
);
  localparam int CW = $clog2(2 * WIN_CLKS + 1);
  localparam logic [CW-1:0] HALF = CW'(WIN_CLKS);
  localparam logic [CW-1:0] LAST = CW'(2 * WIN_CLKS - 1);

  logic          act, man_rst, io_q;
  logic [3:0]    aux;
  logic [CW-1:0] cnt;

  wire rst_phase = cnt >= HALF;
  wire io_fall   = io_q & ~card_io;

  assign vcc_on   = act;
  assign aux_n    = ~aux;
  assign card_rst = act & (auto_on ? rst_phase : man_rst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act        <= 1'b0;
      man_rst    <= 1'b0;
      aux        <= 4'h0;
      auto_on    <= 1'b0;
      cnt        <= '0;
      io_q       <= 1'b1;
      atr_pulse  <= 1'b0;
      mute_pulse <= 1'b0;
      atr_flag   <= 1'b0;
      mute_flag  <= 1'b0;
    end else begin
      io_q       <= card_io;
      atr_pulse  <= 1'b0;
      mute_pulse <= 1'b0;
      if (wr_en) begin
        act       <= wr_data[0];
        man_rst   <= wr_data[1];
        aux       <= wr_data[7:4];
        auto_on   <= wr_data[2] & wr_data[0];
        atr_flag  <= 1'b0;
        mute_flag <= 1'b0;
        if (wr_data[2]) cnt <= '0;
      end else if (auto_on) begin
        if (io_fall && rst_phase) begin
          auto_on   <= 1'b0;
          man_rst   <= 1'b1;
          atr_pulse <= 1'b1;
          atr_flag  <= 1'b1;
        end else if (card_clk_tick) begin
          if (cnt == LAST) begin
            auto_on    <= 1'b0;
            man_rst    <= 1'b0;
            mute_pulse <= 1'b1;
            mute_flag  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  a_r5_atr_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    atr_pulse |-> !auto_on && card_rst && atr_flag);
  a_r7_mute_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    mute_pulse |-> !auto_on && !card_rst && mute_flag);
  a_r6_no_early_atr: assert property (@(posedge clk) disable iff (!rst_n)
    auto_on && !rst_phase && !wr_en |=> !atr_pulse);
  a_r4_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[2] && wr_data[0] |=> auto_on && !card_rst);
  a_r9_deact_abort: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[0] |=> !auto_on && !card_rst && !vcc_on);
  a_r5_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(atr_pulse && mute_pulse));
endmodule

// File: tb/atr_seq_tb_top.sv
module atr_seq_tb_top;
  localparam int W = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, tick = 1'b0, io = 1'b1;
  logic [7:0] wd = 8'h00;
  logic vcc_on, card_rst, auto_on, atr_pulse, mute_pulse, atr_flag, mute_flag;
  logic [3:0] aux_n;
  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  atr_seq #(.WIN_CLKS(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wd),
    .card_clk_tick(tick), .card_io(io), .vcc_on(vcc_on), .card_rst(card_rst),
    .auto_on(auto_on), .aux_n(aux_n), .atr_pulse(atr_pulse),
    .mute_pulse(mute_pulse), .atr_flag(atr_flag), .mute_flag(mute_flag));

  bit m_act, m_man, m_auto, m_io, m_ap, m_mp, m_af, m_mf;
  bit [3:0] m_aux;
  int m_cnt;

  function automatic bit exp_rst();
    return m_act && (m_auto ? (m_cnt >= W) : m_man);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_man = 0; m_auto = 0; m_io = 1; m_ap = 0; m_mp = 0;
      m_af = 0; m_mf = 0; m_aux = 0; m_cnt = 0;
    end else begin
      bit fall;
      fall = m_io && !io;
      m_io = io; m_ap = 0; m_mp = 0;
      if (wr_en) begin
        m_act = wd[0]; m_man = wd[1]; m_aux = wd[7:4];
        m_auto = wd[2] && wd[0]; m_af = 0; m_mf = 0;
        if (wd[2]) m_cnt = 0;
      end else if (m_auto) begin
        if (fall && m_cnt >= W) begin
          m_auto = 0; m_man = 1; m_ap = 1; m_af = 1;
        end else if (tick) begin
          if (m_cnt == 2*W-1) begin
            m_auto = 0; m_man = 0; m_mp = 1; m_mf = 1;
          end else m_cnt++;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 vcc_on", vcc_on, m_act);
    chk("R10 aux_n", aux_n, ~m_aux & 4'hF);
    chk(m_auto ? "R4 card_rst auto" : "R3 card_rst manual", card_rst, exp_rst());
    chk("R5 auto_on", auto_on, m_auto);
    chk("R5 atr_pulse", atr_pulse, m_ap);
    chk("R7 mute_pulse", mute_pulse, m_mp);
    chk("R11 atr_flag", atr_flag, m_af);
    chk("R11 mute_flag", mute_flag, m_mf);
  endtask

  task automatic step(bit w, bit [7:0] d, bit t, bit i);
    wr_en = w; wd = d; tick = t; io = i;
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", cycles, 200000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a7e));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vcc_on", vcc_on, 0); chk("R1 card_rst", card_rst, 0);
    chk("R1 auto_on", auto_on, 0); chk("R1 aux_n", aux_n, 15);
    chk("R1 flags", {atr_flag, mute_flag, atr_pulse, mute_pulse}, 0);

    step(1, 8'h01, 0, 1);
    chk("R3 rst low", card_rst, 0);
    step(1, 8'hA3, 0, 1);
    chk("R3 rst high", card_rst, 1);
    chk("R10 aux", aux_n, 4'h5);

    step(1, 8'h07, 0, 1);
    chk("R4 starts low", card_rst, 0);
    for (int k = 0; k < 5; k++) step(0, 0, 1, 1);
    step(0, 0, 1, 0);
    step(0, 0, 1, 1);
    chk("R6 early edge ignored", auto_on, 1);
    chk("R6 no pulse", atr_flag, 0);
    while (!card_rst) step(0, 0, 1, 1);
    chk("R4 rise tick", m_cnt, W);
    step(0, 0, 0, 0);
    chk("R5 disarm", auto_on, 0); chk("R5 pulse", atr_pulse, 1);
    chk("R5 rst held", card_rst, 1);
    step(0, 0, 0, 1);
    chk("R5 pulse one cycle", atr_pulse, 0); chk("R5 flag", atr_flag, 1);

    step(1, 8'h05, 0, 1);
    chk("R8 warm low", card_rst, 0); chk("R8 vcc kept", vcc_on, 1);
    chk("R11 flag cleared", atr_flag, 0);
    for (int k = 0; k < 2*W - 1; k++) step(0, 0, 1, 1);
    chk("R7 not yet mute", auto_on, 1);
    step(0, 0, 1, 1);
    chk("R7 mute", mute_pulse, 1); chk("R7 rst drop", card_rst, 0);
    chk("R7 disarm", auto_on, 0);

    step(1, 8'h05, 0, 1);
    for (int k = 0; k < W + 3; k++) step(0, 0, 1, 1);
    step(1, 8'h05, 1, 0);
    chk("R8 rerun mid-sequence", card_rst, 0);
    chk("R11 write wins", atr_pulse, 0);
    for (int k = 0; k < W + 3; k++) step(0, 0, 1, 1);
    step(1, 8'h06, 1, 1);
    chk("R9 deact vcc", vcc_on, 0); chk("R9 rst", card_rst, 0);
    chk("R9 auto", auto_on, 0);

    for (int k = 0; k < 4000; k++) begin
      bit w;
      w = ($urandom_range(0, 39) == 0);
      step(w, 8'($urandom), $urandom_range(0, 1) == 1,
           ($urandom_range(0, 7) == 0) ? ~io : io);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule